// File: doc/BRIEF.md
# Debug Trigger Match Combiner

This block sits between an array of debug trigger slots and the core's debug action logic. Each slot reports, for every event class, whether it matched. Each slot also has a chain bit and a 4-bit action code. The block reduces these per-slot results to at most one action request per event class per cycle. There are three event classes: memory access, instruction count and trap.

For memory accesses, a slot with its chain bit set cannot report a match on its own. It only enables the slot after it. A chain of slots therefore reports through its last member, and only when every member of the chain matched. For instruction-count and trap events, the chain bits play no part. These two classes are silenced completely while the core is in debug mode.

Within a class, the eligible match with the numerically largest action code wins. On a tie, the lowest-numbered slot wins. Each class has a registered result: a one-cycle fire pulse, the winning action and the winning slot index. A constant mask reports which trigger types the slots support.

Top module: `trig_match_combiner`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every fire output is 0 and every action and slot output is 0.
- R2: When `mem_req` is high in a cycle and an unchained slot (chain bit 0) has its `mem_hit` bit set, `mem_fire` is high on the following cycle. `mem_act` and `mem_slot` then show the winner. Slot i's action code is `slot_action[4*i+3:4*i]`.
- R3: Memory-access chaining works as a walk over the slots in index order, starting with a "chain ok" flag set to true.
  - A slot seen while the flag is false is skipped, and the flag then becomes the inverse of that slot's chain bit.
  - A slot seen while the flag is true sets the flag to (hit OR NOT chain). It is reportable only if it hit and its chain bit is 0.
- R4: Among the reportable slots of one class, the largest action code wins. When action codes are equal, the lower slot index wins.
- R5: If no slot is reportable during a request, the fire output for that class stays low on the next cycle.
- R6: Instruction-count and trap results ignore all chain bits. Every slot whose hit bit is set is reportable, and selection follows R4.
- R7: While `dbg_mode` is high, `icnt_fire` and `trap_fire` stay low on the next cycle, whatever the hits. Memory-access results are not affected by `dbg_mode`.
- R8: A fire output is high for exactly one cycle per request cycle that has a winner. It is never high after a cycle in which its request input was low.
- R9: `type_mask` is constant 16'h807C, with bits 2, 3, 4, 5, 6 and 15 set.
- R10: Between fire pulses of a class, that class's action and slot outputs keep the values of its last winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_mode | input | 1 | Core is in debug mode |
| slot_chain | input | 4 | Chain bit per slot |
| slot_action | input | 16 | Action code per slot, 4 bits each, slot 0 lowest |
| mem_req | input | 1 | Memory-access event this cycle |
| mem_hit | input | 4 | Memory-access match per slot |
| icnt_req | input | 1 | Instruction-count event this cycle |
| icnt_hit | input | 4 | Instruction-count match per slot |
| trap_req | input | 1 | Trap event this cycle |
| trap_hit | input | 4 | Trap match per slot |
| mem_fire | output | 1 | Memory-access action request pulse |
| mem_act | output | 4 | Winning memory-access action |
| mem_slot | output | 2 | Winning memory-access slot |
| icnt_fire | output | 1 | Instruction-count action request pulse |
| icnt_act | output | 4 | Winning instruction-count action |
| icnt_slot | output | 2 | Winning instruction-count slot |
| trap_fire | output | 1 | Trap action request pulse |
| trap_act | output | 4 | Winning trap action |
| trap_slot | output | 2 | Winning trap slot |
| type_mask | output | 16 | Supported trigger types |

## Verification
The only state the block carries is its per-class result registers. A wrong value in them shows at the ports in the cycle right after the request, or in any later cycle through R10.

Errors in chain handling have no state of their own. They show up on the next cycle as a missing pulse, a spurious pulse or the wrong winning slot. Chain patterns that contain skipped slots, with their chain bit either set or clear, are the inputs that separate a correct walk from a faulty one.

The bench compares all three classes against its own model on every cycle. It uses directed chain and tie patterns and then a long random run.

// File: rtl/trig_comb_pkg.sv
package trig_comb_pkg;

  localparam int unsigned NUM_CLASSES  = 3;
  localparam int unsigned TYPE_MASK_W  = 16;

  // event class numbering used for the per-class generate
  localparam int unsigned CLS_MEM  = 0;
  localparam int unsigned CLS_ICNT = 1;
  localparam int unsigned CLS_TRAP = 2;

  // trigger types the slots can be programmed to
  function automatic logic [TYPE_MASK_W-1:0] supported_types();
    logic [TYPE_MASK_W-1:0] m;
    m = '0;
    for (int t = 2; t <= 6; t++) m[t] = 1'b1;
    m[15] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/trig_chain_gate.sv
// Walks the slots in order and keeps only the matches a chain allows to report.
module trig_chain_gate #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic [NUM_SLOTS-1:0] hit,
  input  logic [NUM_SLOTS-1:0] chain,
  output logic [NUM_SLOTS-1:0] elig
);

  logic run_ok;

  always_comb begin
    run_ok = 1'b1;
    elig   = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!run_ok) begin
        run_ok = ~chain[i];
      end else begin
        elig[i] = hit[i] & ~chain[i];
        run_ok  = hit[i] | ~chain[i];
      end
    end
  end

endmodule

// File: rtl/trig_max_pick.sv
// Picks the eligible slot with the largest action; lower index wins ties.
module trig_max_pick #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned ACT_W     = 4,
  localparam int unsigned IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0]       elig,
  input  logic [NUM_SLOTS*ACT_W-1:0] acts,
  output logic                       found,
  output logic [ACT_W-1:0]           best_act,
  output logic [IDX_W-1:0]           best_idx
);

  always_comb begin
    found    = 1'b0;
    best_act = '0;
    best_idx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (elig[i] && (!found || (acts[i*ACT_W +: ACT_W] > best_act))) begin
        found    = 1'b1;
        best_act = acts[i*ACT_W +: ACT_W];
        best_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/trig_result_reg.sv
// Per-class result register: one-cycle pulse, winner held between pulses.
module trig_result_reg #(
  parameter int unsigned ACT_W = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             found,
  input  logic [ACT_W-1:0] act_in,
  input  logic [IDX_W-1:0] idx_in,
  output logic             fire,
  output logic [ACT_W-1:0] act_q,
  output logic [IDX_W-1:0] idx_q
);

  logic             fire_d;
  logic             load_en;
  logic [ACT_W-1:0] act_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    fire_d  = req & found;
    load_en = fire_d;
    act_d   = load_en ? act_in : act_q;
    idx_d   = load_en ? idx_in : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire  <= 1'b0;
      act_q <= '0;
      idx_q <= '0;
    end else begin
      fire  <= fire_d;
      act_q <= act_d;
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/trig_match_combiner.sv
module trig_match_combiner
  import trig_comb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned ACT_W     = 4,
  localparam int unsigned IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dbg_mode,
  input  logic [NUM_SLOTS-1:0]       slot_chain,
  input  logic [NUM_SLOTS*ACT_W-1:0] slot_action,
  input  logic                       mem_req,
  input  logic [NUM_SLOTS-1:0]       mem_hit,
  input  logic                       icnt_req,
  input  logic [NUM_SLOTS-1:0]       icnt_hit,
  input  logic                       trap_req,
  input  logic [NUM_SLOTS-1:0]       trap_hit,
  output logic                       mem_fire,
  output logic [ACT_W-1:0]           mem_act,
  output logic [IDX_W-1:0]           mem_slot,
  output logic                       icnt_fire,
  output logic [ACT_W-1:0]           icnt_act,
  output logic [IDX_W-1:0]           icnt_slot,
  output logic                       trap_fire,
  output logic [ACT_W-1:0]           trap_act,
  output logic [IDX_W-1:0]           trap_slot,
  output logic [TYPE_MASK_W-1:0]     type_mask
);

  logic [NUM_SLOTS-1:0] hit_bus  [NUM_CLASSES];
  logic                 req_bus  [NUM_CLASSES];
  logic                 fire_bus [NUM_CLASSES];
  logic [ACT_W-1:0]     act_bus  [NUM_CLASSES];
  logic [IDX_W-1:0]     idx_bus  [NUM_CLASSES];

  assign hit_bus[CLS_MEM]  = mem_hit;
  assign hit_bus[CLS_ICNT] = icnt_hit;
  assign hit_bus[CLS_TRAP] = trap_hit;
  assign req_bus[CLS_MEM]  = mem_req;
  assign req_bus[CLS_ICNT] = icnt_req;
  assign req_bus[CLS_TRAP] = trap_req;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
    logic [NUM_SLOTS-1:0] elig;
    logic                 found;
    logic [ACT_W-1:0]     win_act;
    logic [IDX_W-1:0]     win_idx;

    if (c == CLS_MEM) begin : g_chained
      trig_chain_gate #(.NUM_SLOTS(NUM_SLOTS)) u_gate (
        .hit   (hit_bus[c]),
        .chain (slot_chain),
        .elig  (elig)
      );
    end else begin : g_flat
      assign elig = hit_bus[c] & {NUM_SLOTS{~dbg_mode}};
    end

    trig_max_pick #(.NUM_SLOTS(NUM_SLOTS), .ACT_W(ACT_W)) u_pick (
      .elig     (elig),
      .acts     (slot_action),
      .found    (found),
      .best_act (win_act),
      .best_idx (win_idx)
    );

    trig_result_reg #(.ACT_W(ACT_W), .IDX_W(IDX_W)) u_res (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req_bus[c]),
      .found  (found),
      .act_in (win_act),
      .idx_in (win_idx),
      .fire   (fire_bus[c]),
      .act_q  (act_bus[c]),
      .idx_q  (idx_bus[c])
    );
  end

  assign mem_fire  = fire_bus[CLS_MEM];
  assign mem_act   = act_bus[CLS_MEM];
  assign mem_slot  = idx_bus[CLS_MEM];
  assign icnt_fire = fire_bus[CLS_ICNT];
  assign icnt_act  = act_bus[CLS_ICNT];
  assign icnt_slot = idx_bus[CLS_ICNT];
  assign trap_fire = fire_bus[CLS_TRAP];
  assign trap_act  = act_bus[CLS_TRAP];
  assign trap_slot = idx_bus[CLS_TRAP];

  assign type_mask = supported_types();

endmodule

// File: rtl/trig_match_combiner_chk.sv
module trig_match_combiner_chk #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned ACT_W     = 4,
  localparam int unsigned IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dbg_mode,
  input logic [NUM_SLOTS-1:0] slot_chain,
  input logic                 mem_req,
  input logic [NUM_SLOTS-1:0] mem_hit,
  input logic                 icnt_req,
  input logic [NUM_SLOTS-1:0] icnt_hit,
  input logic                 trap_req,
  input logic [NUM_SLOTS-1:0] trap_hit,
  input logic                 mem_fire,
  input logic [IDX_W-1:0]     mem_slot,
  input logic                 icnt_fire,
  input logic [IDX_W-1:0]     icnt_slot,
  input logic                 trap_fire,
  input logic [IDX_W-1:0]     trap_slot
);

  logic [NUM_SLOTS-1:0] chain_q, mem_hit_q, icnt_hit_q, trap_hit_q;
  logic                 dbg_q, mem_req_q, icnt_req_q, trap_req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q    <= '0;
      mem_hit_q  <= '0;
      icnt_hit_q <= '0;
      trap_hit_q <= '0;
      dbg_q      <= 1'b0;
      mem_req_q  <= 1'b0;
      icnt_req_q <= 1'b0;
      trap_req_q <= 1'b0;
    end else begin
      chain_q    <= slot_chain;
      mem_hit_q  <= mem_hit;
      icnt_hit_q <= icnt_hit;
      trap_hit_q <= trap_hit;
      dbg_q      <= dbg_mode;
      mem_req_q  <= mem_req;
      icnt_req_q <= icnt_req;
      trap_req_q <= trap_req;
    end
  end

  p_mem_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire |-> mem_req_q);
  p_icnt_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    icnt_fire |-> icnt_req_q);
  p_trap_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |-> trap_req_q);

  // R3: the memory winner hit and is the unchained end of its chain
  p_mem_unchained_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire |-> (mem_hit_q[mem_slot] && !chain_q[mem_slot]));

  p_no_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|mem_hit_q) |-> !mem_fire);

  p_icnt_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    icnt_fire |-> icnt_hit_q[icnt_slot]);
  p_trap_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |-> trap_hit_q[trap_slot]);

  p_dbg_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_q |-> (!icnt_fire && !trap_fire));

  p_hold_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_fire |-> $stable(mem_slot));

endmodule

bind trig_match_combiner trig_match_combiner_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .ACT_W     (ACT_W)
) u_chk (.*);

// File: tb/sim_trig_match_combiner.sv
`timescale 1ns/1ps
module sim_trig_match_combiner;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_mode = 1'b0;
  logic [3:0]  slot_chain = '0;
  logic [15:0] slot_action = '0;
  logic        mem_req = 1'b0, icnt_req = 1'b0, trap_req = 1'b0;
  logic [3:0]  mem_hit = '0, icnt_hit = '0, trap_hit = '0;
  logic        mem_fire, icnt_fire, trap_fire;
  logic [3:0]  mem_act, icnt_act, trap_act;
  logic [1:0]  mem_slot, icnt_slot, trap_slot;
  logic [15:0] type_mask;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  string exp_tag = "R1";
  bit run = 1'b1;

  int exp_f [3];
  int exp_a [3];
  int exp_s [3];

  always #2 clk = ~clk;

  trig_match_combiner u0 (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode),
    .slot_chain(slot_chain), .slot_action(slot_action),
    .mem_req(mem_req), .mem_hit(mem_hit),
    .icnt_req(icnt_req), .icnt_hit(icnt_hit),
    .trap_req(trap_req), .trap_hit(trap_hit),
    .mem_fire(mem_fire), .mem_act(mem_act), .mem_slot(mem_slot),
    .icnt_fire(icnt_fire), .icnt_act(icnt_act), .icnt_slot(icnt_slot),
    .trap_fire(trap_fire), .trap_act(trap_act), .trap_slot(trap_slot),
    .type_mask(type_mask)
  );

  // Reference: a memory slot reports when it ends a chain group whose
  // members all hit; other classes report any hit outside debug mode.
  function automatic void model_pick(input int cls, output bit f,
                                     output int a, output int s);
    bit cand [4];
    bit all_hit = 1'b1;
    logic [3:0] h;
    h = (cls == 0) ? mem_hit : (cls == 1) ? icnt_hit : trap_hit;
    for (int i = 0; i < 4; i++) begin
      if (cls == 0) begin
        all_hit = all_hit && h[i];
        cand[i] = 1'b0;
        if (!slot_chain[i]) begin
          cand[i] = all_hit;
          all_hit = 1'b1;
        end
      end else begin
        cand[i] = h[i] && !dbg_mode;
      end
    end
    f = 1'b0; a = 0; s = 0;
    for (int i = 3; i >= 0; i--) begin
      int v;
      v = int'(slot_action[i*4 +: 4]);
      if (cand[i] && (!f || v >= a)) begin
        f = 1'b1; a = v; s = i;
      end
    end
  endfunction

  always @(negedge clk) begin
    if (run) begin
      for (int c = 0; c < 3; c++) begin
        int gf, ga, gs;
        gf = (c == 0) ? int'(mem_fire) : (c == 1) ? int'(icnt_fire) : int'(trap_fire);
        ga = (c == 0) ? int'(mem_act)  : (c == 1) ? int'(icnt_act)  : int'(trap_act);
        gs = (c == 0) ? int'(mem_slot) : (c == 1) ? int'(icnt_slot) : int'(trap_slot);
        checks++;
        if (gf != exp_f[c] || ga != exp_a[c] || gs != exp_s[c]) begin
          errors++;
          $display("FAIL %s class %0d: actual fire=%0d act=%0d slot=%0d expected fire=%0d act=%0d slot=%0d",
                   exp_tag, c, gf, ga, gs, exp_f[c], exp_a[c], exp_s[c]);
        end
      end
      for (int c = 0; c < 3; c++) begin
        bit f; int a, s; logic rq;
        rq = (c == 0) ? mem_req : (c == 1) ? icnt_req : trap_req;
        model_pick(c, f, a, s);
        if (!rst_n) begin
          exp_f[c] = 0; exp_a[c] = 0; exp_s[c] = 0;
        end else if (rq && f) begin
          exp_f[c] = 1; exp_a[c] = a; exp_s[c] = s;
        end else begin
          exp_f[c] = 0;
        end
      end
      exp_tag = cur_tag;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic quiet();
    mem_req = 0; icnt_req = 0; trap_req = 0;
    tick();
  endtask

  task automatic acts(input int a0, a1, a2, a3);
    slot_action = {4'(a3), 4'(a2), 4'(a1), 4'(a0)};
  endtask

  task automatic mem_ev(input string tag, input logic [3:0] ch, input logic [3:0] h);
    cur_tag = tag; slot_chain = ch; mem_hit = h; mem_req = 1; tick(); quiet();
  endtask

  initial begin
    for (int c = 0; c < 3; c++) begin exp_f[c] = 0; exp_a[c] = 0; exp_s[c] = 0; end
    cur_tag = "R1";
    repeat (3) tick();
    rst_n = 1; tick(); tick();

    checks++;
    if (type_mask !== 16'h807C) begin
      errors++;
      $display("FAIL R9: actual %h expected 807c", type_mask);
    end

    acts(5, 7, 3, 2);
    mem_ev("R2", 4'b0000, 4'b0001);
    mem_ev("R3", 4'b0001, 4'b0011);          // chain 0->1, both hit: slot1
    mem_ev("R3", 4'b0001, 4'b0010);          // slot0 missed: slot1 skipped
    mem_ev("R3", 4'b0011, 4'b1100);          // skipped run, slot3 evaluated
    mem_ev("R3", 4'b0101, 4'b1110);          // slot0 miss, skip 1, slot2 chain -> 3
    mem_ev("R3", 4'b1000, 4'b1000);          // trailing chained slot never reports
    acts(3, 9, 9, 1);
    mem_ev("R4", 4'b0000, 4'b1111);          // tie 9/9: slot1
    acts(2, 2, 2, 2);
    mem_ev("R4", 4'b0000, 4'b1110);          // all equal: lowest index
    cur_tag = "R10"; repeat (3) tick();
    mem_ev("R5", 4'b0000, 4'b0000);

    acts(1, 0, 4, 6);
    cur_tag = "R6"; slot_chain = 4'b1111;
    icnt_hit = 4'b0100; icnt_req = 1; trap_hit = 4'b1101; trap_req = 1; tick(); quiet();
    cur_tag = "R7"; dbg_mode = 1; icnt_req = 1; trap_req = 1; mem_req = 1;
    slot_chain = 4'b0000; mem_hit = 4'b0001; tick(); quiet(); dbg_mode = 0;
    cur_tag = "R8"; icnt_req = 0; icnt_hit = 4'b1111; tick(); tick();
    icnt_req = 1; tick(); quiet(); tick();

    cur_tag = "R4";
    for (int n = 0; n < 3000; n++) begin
      dbg_mode    = ($urandom_range(0, 7) == 0);
      slot_chain  = 4'($urandom);
      slot_action = 16'($urandom);
      mem_hit = 4'($urandom); icnt_hit = 4'($urandom); trap_hit = 4'($urandom);
      mem_req = 1'($urandom); icnt_req = 1'($urandom); trap_req = 1'($urandom);
      tick();
    end
    quiet(); tick();
    run = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    run = 1'b0;
    errors++; checks++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule